// File: doc/BRIEF.md
# Six-Operand Carry-Save Adder

This block adds six signed 4-bit integers in one combinational pass and returns a 6-bit two's complement total. It does not carry-propagate at every step. Instead it first widens each operand to the result width by copying its sign bit. Two layers of 4:2 compressors then reduce the six words to a sum word and a carry word. A single ordinary addition joins those two words at the end.

Each 4:2 compressor is two chained full adders. The full adder cells use only XOR, AND, OR and inversion. Within a compressor, the first full adder takes three inputs, and its carry leaves sideways to the next bit position. The second full adder folds in the fourth input and the carry that arrives from the bit below.

The sideways carry-out never depends on the sideways carry-in, so no carry ripples across a layer. Carries that would land at weight 64 are discarded. The output is therefore the true total modulo 64.

The block is purely combinational, with no clock and no handshake. A caller drives the operands and reads the result in the same cycle.

Top module: `six_operand_adder`

## Requirements
- R1: The output equals the sum of the six sign-extended operands modulo 64, for every combination of operand values.
- R2: Whenever the true sum lies in -32..31, the output read as a signed 6-bit value equals that sum exactly, including the end values -32 (output 6'b100000) and 31 (output 6'b011111).
- R3: With operands 4 and 5 held at zero, the output equals the modulo-64 sum of operands 0 to 3, which the first compressor layer reduces.
- R4: With operands 0 to 3 held at zero, the output equals the modulo-64 sum of operands 4 and 5, which enter only at the second compressor layer.
- R5: The output does not depend on which port carries which value: any rotation of the same six values gives the same output.
- R6: A negative operand is sign-extended. A single operand of -8 with the rest zero gives 6'b111000, and a single -1 gives 6'b111111.
- R7: With all six operands zero, the output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op0 | input | 4 | Operand 0, signed two's complement |
| op1 | input | 4 | Operand 1, signed two's complement |
| op2 | input | 4 | Operand 2, signed two's complement |
| op3 | input | 4 | Operand 3, signed two's complement |
| op4 | input | 4 | Operand 4, signed two's complement |
| op5 | input | 4 | Operand 5, signed two's complement |
| total | output | 6 | Sum modulo 64, two's complement |

## Verification
The bench targets the end values of the operand range: 7 and -8 placed alone in each port position, all ones and all minus ones, and the two vectors that land exactly on 31 and -32. A design that fails to widen the sign would return 8 instead of -8. A compressor wired with its lateral carry into the wrong bit would be off by a power of two on the mixed vectors. A final stage that drops the top bit would flip the sign of the -32 case. The bench also sends operands only through the first layer, and separately only through the second layer, so that a fault in either one shows up alone. Finally, it rotates each random vector across the ports, which exposes an input that has been wired unevenly into the tree.

// File: rtl/six_add_pkg.sv
package six_add_pkg;
  localparam int OP_W  = 4;
  localparam int SUM_W = 6;
  localparam int N_OPS = 6;
  typedef logic [SUM_W-1:0] word_t;
endpackage

// File: rtl/csa_fa.sv
// Full adder cell: three equal-weight bits in, sum and carry out.
module csa_fa (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic co
);
  logic half;
  assign half = a ^ b;
  assign s    = half ^ cin;
  assign co   = (a & b) | (cin & half);
endmodule

// File: rtl/csa_c42.sv
// 4:2 compressor: the lateral carry-out comes only from a, b, c,
// so it never waits on the lateral carry-in.
module csa_c42 (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic lat_in,
  output logic lat_out,
  output logic carry,
  output logic sum
);
  logic mid;
  csa_fa u_first  (.a(a),   .b(b), .cin(c),      .s(mid), .co(lat_out));
  csa_fa u_second (.a(mid), .b(d), .cin(lat_in), .s(sum), .co(carry));
endmodule

// File: rtl/csa_layer.sv
// One row of 4:2 compressors over W bit positions. The carry word is
// returned already shifted to its weight; anything reaching 2^W is dropped.
module csa_layer #(
  parameter int W = 6
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic [W-1:0] in_d,
  output logic [W-1:0] sum_w,
  output logic [W-1:0] carry_w
);
  logic [W-1:0] lat;
  logic [W-1:0] cin_v;

  assign cin_v[0]   = 1'b0;
  assign carry_w[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i > 0) begin : g_link
      assign cin_v[i] = lat[i-1];
    end
    if (i < W-1) begin : g_full
      logic cy;
      csa_c42 u_c42 (
        .a(in_a[i]), .b(in_b[i]), .c(in_c[i]), .d(in_d[i]),
        .lat_in(cin_v[i]), .lat_out(lat[i]), .carry(cy), .sum(sum_w[i])
      );
      assign carry_w[i+1] = cy;
    end else begin : g_top
      // Top position: both carries weigh 2^W and are discarded, only parity remains.
      assign lat[i]   = 1'b0;
      assign sum_w[i] = in_a[i] ^ in_b[i] ^ in_c[i] ^ in_d[i] ^ cin_v[i];
    end
  end
endmodule

// File: rtl/six_operand_adder.sv
module six_operand_adder
  import six_add_pkg::*;
#(
  parameter int IN_W  = OP_W,
  parameter int OUT_W = SUM_W
) (
  input  logic [IN_W-1:0]  op0,
  input  logic [IN_W-1:0]  op1,
  input  logic [IN_W-1:0]  op2,
  input  logic [IN_W-1:0]  op3,
  input  logic [IN_W-1:0]  op4,
  input  logic [IN_W-1:0]  op5,
  output logic [OUT_W-1:0] total
);
  localparam int EXT = OUT_W - IN_W;

  logic [IN_W-1:0]  raw [N_OPS];
  logic [OUT_W-1:0] ext [N_OPS];
  logic [OUT_W-1:0] l1_sum, l1_carry, l2_sum, l2_carry;

  assign raw[0] = op0;
  assign raw[1] = op1;
  assign raw[2] = op2;
  assign raw[3] = op3;
  assign raw[4] = op4;
  assign raw[5] = op5;

  for (genvar k = 0; k < N_OPS; k++) begin : g_ext
    assign ext[k] = {{EXT{raw[k][IN_W-1]}}, raw[k]};
  end

  csa_layer #(.W(OUT_W)) u_layer1 (
    .in_a(ext[0]), .in_b(ext[1]), .in_c(ext[2]), .in_d(ext[3]),
    .sum_w(l1_sum), .carry_w(l1_carry)
  );

  csa_layer #(.W(OUT_W)) u_layer2 (
    .in_a(ext[4]), .in_b(ext[5]), .in_c(l1_sum), .in_d(l1_carry),
    .sum_w(l2_sum), .carry_w(l2_carry)
  );

  assign total = l2_sum + l2_carry;
endmodule

// File: rtl/six_add_checker.sv
module six_add_checker #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 6
) (
  input logic [IN_W-1:0]  op0,
  input logic [IN_W-1:0]  op1,
  input logic [IN_W-1:0]  op2,
  input logic [IN_W-1:0]  op3,
  input logic [IN_W-1:0]  op4,
  input logic [IN_W-1:0]  op5,
  input logic [OUT_W-1:0] l1_sum,
  input logic [OUT_W-1:0] l1_carry,
  input logic [OUT_W-1:0] l2_sum,
  input logic [OUT_W-1:0] l2_carry,
  input logic [OUT_W-1:0] total
);
  int part4, full6;
  logic [OUT_W-1:0] l1_pair, l2_pair;

  always_comb begin
    part4 = int'($signed(op0)) + int'($signed(op1)) + int'($signed(op2)) + int'($signed(op3));
    full6 = part4 + int'($signed(op4)) + int'($signed(op5));
    l1_pair = l1_sum + l1_carry;
    l2_pair = l2_sum + l2_carry;
  end

  always_comb begin
    assert_layer1_R3: assert (l1_pair == OUT_W'(part4))
      else $error("layer1 pair %0d vs %0d", l1_pair, part4);
    assert_layer2_R4: assert (l2_pair == OUT_W'(full6))
      else $error("layer2 pair %0d vs %0d", l2_pair, full6);
    assert_total_mod_R1: assert (total == OUT_W'(full6))
      else $error("total %0d vs %0d", total, full6);
    if (full6 >= -(1 << (OUT_W-1)) && full6 < (1 << (OUT_W-1))) begin
      assert_in_range_R2: assert (int'($signed(total)) == full6)
        else $error("signed total %0d vs %0d", $signed(total), full6);
    end
  end
endmodule

bind six_operand_adder six_add_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_six_add_checker (
  .op0(op0), .op1(op1), .op2(op2), .op3(op3), .op4(op4), .op5(op5),
  .l1_sum(l1_sum), .l1_carry(l1_carry), .l2_sum(l2_sum), .l2_carry(l2_carry),
  .total(total)
);

// File: tb/test_six_operand_adder.sv
module test_six_operand_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] op [6];
  logic [5:0] total;
  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;

  six_operand_adder i_six_operand_adder (
    .op0(op[0]), .op1(op[1]), .op2(op[2]), .op3(op[3]), .op4(op[4]), .op5(op[5]),
    .total(total)
  );

  function automatic int true_sum(input int v0, v1, v2, v3, v4, v5);
    return v0 + v1 + v2 + v3 + v4 + v5;
  endfunction

  task automatic drive(input int v0, v1, v2, v3, v4, v5);
    @(negedge clk);
    op[0] = 4'(v0); op[1] = 4'(v1); op[2] = 4'(v2);
    op[3] = 4'(v3); op[4] = 4'(v4); op[5] = 4'(v5);
    @(posedge clk);
    #1;
  endtask

  task automatic expect_eq(input string req, input logic [5:0] exp);
    n_checks++;
    if (total !== exp) begin
      n_errs++;
      $display("FAIL %s: ops=%0d,%0d,%0d,%0d,%0d,%0d total=%b expected=%b", req,
               $signed(op[0]), $signed(op[1]), $signed(op[2]), $signed(op[3]),
               $signed(op[4]), $signed(op[5]), total, exp);
    end
  endtask

  // Applies a vector and checks the modulo result, plus the exact signed value when in range.
  task automatic run_vec(input string req, input int v0, v1, v2, v3, v4, v5);
    int s;
    s = true_sum(v0, v1, v2, v3, v4, v5);
    drive(v0, v1, v2, v3, v4, v5);
    expect_eq(req, 6'(s));
    if (s >= -32 && s <= 31) begin
      n_checks++;
      if (int'($signed(total)) != s) begin
        n_errs++;
        $display("FAIL R2: signed total=%0d expected=%0d", $signed(total), s);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: run hung, elapsed=100000 expected<100000");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin : stim
    int vals [6];
    logic [5:0] first;
    void'($urandom(32'd2024));
    for (int k = 0; k < 6; k++) op[k] = 4'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R7: idle state
    run_vec("R7", 0, 0, 0, 0, 0, 0);

    // Single operand at each position: R1 for 1 and 7, R6 for -1 and -8
    for (int p = 0; p < 6; p++) begin
      int v [5];
      v = '{1, -1, 7, -8, 0};
      for (int q = 0; q < 5; q++) begin
        int a [6];
        a = '{0, 0, 0, 0, 0, 0};
        a[p] = v[q];
        run_vec((v[q] < 0) ? "R6" : "R1", a[0], a[1], a[2], a[3], a[4], a[5]);
      end
    end
    drive(-8, 0, 0, 0, 0, 0); expect_eq("R6", 6'b111000);
    drive(0, 0, 0, 0, 0, -1); expect_eq("R6", 6'b111111);

    run_vec("R1", 1, 1, 1, 1, 1, 1);
    run_vec("R1", -1, -1, -1, -1, -1, -1);
    run_vec("R1", 1, 2, 3, 4, 5, 6);
    // R2 end points
    drive(7, 4, 5, 5, 5, 5);       expect_eq("R2", 6'b011111);
    drive(-7, -5, -5, -5, -5, -5); expect_eq("R2", 6'b100000);
    run_vec("R1", -8, -8, -8, -8, -8, -8);
    run_vec("R1", 7, 7, 7, 7, 7, 7);

    // R3: first layer only; R4: second layer only
    run_vec("R3", 7, 7, 7, 7, 0, 0);
    run_vec("R3", -8, 7, -8, 3, 0, 0);
    run_vec("R4", 0, 0, 0, 0, 7, -8);
    run_vec("R4", 0, 0, 0, 0, -8, -8);

    for (int t = 0; t < 400; t++) begin
      for (int k = 0; k < 6; k++) vals[k] = int'($signed(4'($urandom)));
      if (t % 4 == 1) begin vals[4] = 0; vals[5] = 0; end
      if (t % 4 == 2) begin vals[0] = 0; vals[1] = 0; vals[2] = 0; vals[3] = 0; end
      run_vec((t % 4 == 1) ? "R3" : (t % 4 == 2) ? "R4" : "R1",
              vals[0], vals[1], vals[2], vals[3], vals[4], vals[5]);
      first = total;
      // R5: rotate the same values across the ports
      drive(vals[1], vals[2], vals[3], vals[4], vals[5], vals[0]);
      expect_eq("R5", first);
      drive(vals[3], vals[4], vals[5], vals[0], vals[1], vals[2]);
      expect_eq("R5", first);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule